// File: doc/BRIEF.md
# Command-queue I2C master

This block is an I2C bus master steered entirely by a stream of command bytes. Software pushes bytes into a four-entry command queue; a sequencer takes them one at a time and turns each into bus activity: a start or stop condition, a single data bit, a full byte shifted out MSB first, a byte clocked in from the slave, or a check of the slave acknowledge. A byte-send command takes the queue entry after it as its payload, whatever that value is. Received bytes go into a four-entry receive queue that software drains.

The bus pins are open-drain: the block only ever pulls SCL or SDA low or releases them. The incoming SDA level passes through a two-flop synchroniser before it is sampled. All bus timing comes from one tick whose period is set by a divide field and a prescale field. Status outputs report an empty command queue, a dropped command write, a read from an empty receive queue, data waiting in the receive queue and a missing acknowledge. Popping the receive queue clears the sticky flags.

Top module: `i2c_cmdq_master`

## Requirements
- R1: After reset both bus lines are released (high), the command queue reports empty and the overflow, underflow, data-ready and bus-error flags are all 0.
- R2: Command 0x15 produces a start: SCL is raised with SDA released, then SDA is pulled low while SCL stays high, then SCL is pulled low. Command 0x16 produces a stop: SDA is held low while SCL rises, then SDA is released while SCL stays high.
- R3: Command 0x10 sends one bit of value 0 and command 0x11 sends one bit of value 1 (SDA released), each as one SCL high pulse.
- R4: Command 0x12 takes the next command-queue entry as a data byte and sends its 8 bits MSB first; that entry is never decoded as a command, including the value 0x13 arriving as the only entry after the queue had gone empty.
- R5: Command 0x13 releases SDA for 8 SCL pulses, samples SDA on each (first sample is the MSB), and pushes the byte into the receive queue; rxq_ready is 1 while the queue holds data, rxq_rdata shows the oldest byte, and bytes leave in arrival order.
- R6: Command 0x14 releases SDA for one SCL pulse; a high level sampled there sets bus_err, a low level leaves it unchanged.
- R7: A command write while the command queue holds 4 entries is discarded and sets cmdq_ovf; cmdq_ovf returns to 0 in the first cycle in which the queue is below 4 entries.
- R8: A receive-queue read while the receive queue is empty sets rxq_ufl.
- R9: Any receive-queue read clears rxq_ufl and bus_err; in the same cycle a setting event (empty-queue read, missing acknowledge) takes precedence over the clear.
- R10: Code 0x00 and any code outside 0x10 to 0x16 are consumed with no bus activity.
- R11: One tick lasts (prescale * 2^DIV_W + div_lo + 1) clock cycles, a prescale of 0 acting as 1; within a byte, successive SCL rising edges are 3 ticks apart.
- R12: cmdq_empty is 1 exactly when the command queue holds no entry, including while a byte command waits for its payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command queue |
| cmd_wdata | input | 8 | Command or payload byte |
| rxq_re | input | 1 | Read strobe for the receive queue; clears sticky flags |
| rxq_rdata | output | 8 | Oldest byte in the receive queue |
| div_lo | input | DIV_W | Low part of the tick divisor |
| prescale | input | PRE_W | High part of the tick divisor; 0 acts as 1 |
| sda_i | input | 1 | Level on the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cmdq_empty | output | 1 | Command queue holds no entry |
| cmdq_ovf | output | 1 | A command write was dropped on a full queue |
| rxq_ufl | output | 1 | Receive queue was read while empty |
| rxq_ready | output | 1 | Receive queue holds data |
| bus_err | output | 1 | Slave acknowledge was missing |

## Verification
The receive-queue read clears the sticky flags while an empty-queue read sets underflow, so a clear and a set meet in one cycle. The bench first leaves bus_err set by a missing acknowledge, then reads the empty receive queue and expects bus_err cleared yet rxq_ufl set, then reads again with the queue still empty to see underflow stay up. A later read on a filled queue must drop both flags, showing the clear is not masked permanently.

// File: rtl/i2c_cmdq_pkg.sv
`timescale 1ns/1ps
// Package: command codes and state types shared by the command-queue I2C master.
// Assumes byte-wide commands; codes outside the listed set are treated as no-ops.
package i2c_cmdq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] CMD_NOP    = 8'h00;
    localparam logic [7:0] CMD_BIT0   = 8'h10;
    localparam logic [7:0] CMD_BIT1   = 8'h11;
    localparam logic [7:0] CMD_TXBYTE = 8'h12;
    localparam logic [7:0] CMD_RXBYTE = 8'h13;
    localparam logic [7:0] CMD_ACKCHK = 8'h14;
    localparam logic [7:0] CMD_START  = 8'h15;
    localparam logic [7:0] CMD_STOP   = 8'h16;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_OPERAND,
        SEQ_RUN
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_SEND,
        OP_RECV,
        OP_ACK,
        OP_START,
        OP_STOP
    } bus_op_t;

endpackage

// File: rtl/i2c_cmdq_fifo.sv
`timescale 1ns/1ps
// Module: small first-word-fall-through queue.
// Assumes the caller never pushes when full nor pops when empty.
module i2c_cmdq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    cnt;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= next_ptr(wptr);
            if (pop)  rptr <= next_ptr(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign rdata = mem[rptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    assert_push_not_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_not_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/i2c_cmdq_tick.sv
`timescale 1ns/1ps
// Module: free-running tick generator for bus timing.
// Period is {prescale, div_lo} + 1 cycles; a zero prescale is forced to one.
module i2c_cmdq_tick #(
    parameter int DIV_W = 5,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_lo,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    localparam int CNT_W = DIV_W + PRE_W;

    logic [PRE_W-1:0] pre_eff;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;

    assign pre_eff = (prescale == '0) ? PRE_W'(1) : prescale;
    assign limit   = {pre_eff, div_lo};
    assign tick    = (cnt >= limit);

    // Count up to the limit, then restart.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    assert_tick_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/i2c_cmdq_seq.sv
`timescale 1ns/1ps
// Module: command decoder and bit-level SCL/SDA sequencer.
// Assumes sda_s is already synchronised. Data bits take three ticks
// (SCL low with new data, SCL high, SCL low after sampling); bus is parked
// with SCL low between commands except after a stop.
module i2c_cmdq_seq
    import i2c_cmdq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_rdata,
    output logic              q_pop,
    input  logic              sda_s,
    output logic              scl_low,
    output logic              sda_low,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              nack_set
);
    seq_state_t        st;
    bus_op_t           op;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic [1:0]        phase;

    // Consume a queue entry whenever the sequencer is ready for one.
    assign q_pop   = (st != SEQ_RUN) && !q_empty;
    assign rx_byte = shreg;

    // Decode, then step through the bus phases on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            op       <= OP_SEND;
            shreg    <= '0;
            bitcnt   <= '0;
            phase    <= '0;
            scl_low  <= 1'b0;
            sda_low  <= 1'b0;
            rx_push  <= 1'b0;
            nack_set <= 1'b0;
        end else begin
            rx_push  <= 1'b0;
            nack_set <= 1'b0;
            case (st)
                SEQ_IDLE: begin
                    if (!q_empty) begin
                        phase <= '0;
                        case (q_rdata)
                            CMD_BIT0:   begin op <= OP_SEND;  shreg <= 8'h00; bitcnt <= 4'd1; st <= SEQ_RUN; end
                            CMD_BIT1:   begin op <= OP_SEND;  shreg <= 8'h80; bitcnt <= 4'd1; st <= SEQ_RUN; end
                            CMD_TXBYTE: st <= SEQ_OPERAND;
                            CMD_RXBYTE: begin op <= OP_RECV;  bitcnt <= 4'd8; st <= SEQ_RUN; end
                            CMD_ACKCHK: begin op <= OP_ACK;   bitcnt <= 4'd1; st <= SEQ_RUN; end
                            CMD_START:  begin op <= OP_START; st <= SEQ_RUN; end
                            CMD_STOP:   begin op <= OP_STOP;  st <= SEQ_RUN; end
                            CMD_NOP:    st <= SEQ_IDLE;
                            default:    st <= SEQ_IDLE;
                        endcase
                    end
                end
                SEQ_OPERAND: begin
                    if (!q_empty) begin
                        op     <= OP_SEND;
                        shreg  <= q_rdata;
                        bitcnt <= 4'd8;
                        phase  <= '0;
                        st     <= SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (tick) begin
                        case (op)
                            OP_START: begin
                                case (phase)
                                    2'd0: begin scl_low <= 1'b1; sda_low <= 1'b0; end
                                    2'd1: scl_low <= 1'b0;
                                    2'd2: sda_low <= 1'b1;
                                    default: begin scl_low <= 1'b1; st <= SEQ_IDLE; end
                                endcase
                                phase <= phase + 1'b1;
                            end
                            OP_STOP: begin
                                case (phase)
                                    2'd0: begin scl_low <= 1'b1; sda_low <= 1'b1; end
                                    2'd1: scl_low <= 1'b0;
                                    default: begin sda_low <= 1'b0; st <= SEQ_IDLE; end
                                endcase
                                phase <= phase + 1'b1;
                            end
                            default: begin
                                case (phase)
                                    2'd0: begin
                                        scl_low <= 1'b1;
                                        sda_low <= (op == OP_SEND) ? ~shreg[BYTE_W-1] : 1'b0;
                                        phase   <= 2'd1;
                                    end
                                    2'd1: begin
                                        scl_low <= 1'b0;
                                        phase   <= 2'd2;
                                    end
                                    default: begin
                                        scl_low <= 1'b1;
                                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                                        bitcnt  <= bitcnt - 1'b1;
                                        phase   <= 2'd0;
                                        if (bitcnt == 4'd1) begin
                                            st       <= SEQ_IDLE;
                                            rx_push  <= (op == OP_RECV);
                                            nack_set <= (op == OP_ACK) && sda_s;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assert_sda_moves_high_scl_only_framing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_low && $past(!scl_low) && (sda_low != $past(sda_low)))
            |-> (op == OP_START || op == OP_STOP));
    assert_nack_from_ackchk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nack_set |-> (op == OP_ACK));
    assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);

endmodule

// File: rtl/i2c_cmdq_master.sv
`timescale 1ns/1ps
// Module: command-queue I2C master top level.
// Wires command queue, receive queue, tick generator and sequencer, holds the
// SDA synchroniser and the status flags. Assumes a single master and no
// clock stretching by the slave.
module i2c_cmdq_master
    import i2c_cmdq_pkg::*;
#(
    parameter int DIV_W      = 5,
    parameter int PRE_W      = 8,
    parameter int CMDQ_DEPTH = 4,
    parameter int RXQ_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_wdata,
    input  logic              rxq_re,
    output logic [BYTE_W-1:0] rxq_rdata,
    input  logic [DIV_W-1:0]  div_lo,
    input  logic [PRE_W-1:0]  prescale,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic              cmdq_empty,
    output logic              cmdq_ovf,
    output logic              rxq_ufl,
    output logic              rxq_ready,
    output logic              bus_err
);
    logic              cmdq_full;
    logic              cmdq_pop;
    logic [BYTE_W-1:0] cmdq_head;
    logic              rxq_full;
    logic              rxq_empty;
    logic              rx_push;
    logic [BYTE_W-1:0] rx_byte;
    logic              nack_set;
    logic              tick;
    logic [1:0]        sda_sync;

    i2c_cmdq_fifo #(.WIDTH(BYTE_W), .DEPTH(CMDQ_DEPTH)) u_cmdq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_we && !cmdq_full),
        .wdata (cmd_wdata),
        .pop   (cmdq_pop),
        .rdata (cmdq_head),
        .empty (cmdq_empty),
        .full  (cmdq_full)
    );

    i2c_cmdq_fifo #(.WIDTH(BYTE_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push && !rxq_full),
        .wdata (rx_byte),
        .pop   (rxq_re && !rxq_empty),
        .rdata (rxq_rdata),
        .empty (rxq_empty),
        .full  (rxq_full)
    );

    i2c_cmdq_tick #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_lo   (div_lo),
        .prescale (prescale),
        .tick     (tick)
    );

    i2c_cmdq_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .q_empty  (cmdq_empty),
        .q_rdata  (cmdq_head),
        .q_pop    (cmdq_pop),
        .sda_s    (sda_sync[1]),
        .scl_low  (scl_drive_low),
        .sda_low  (sda_drive_low),
        .rx_push  (rx_push),
        .rx_byte  (rx_byte),
        .nack_set (nack_set)
    );

    assign rxq_ready = !rxq_empty;

    // Two-flop synchroniser for the incoming SDA level.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_sync <= 2'b11;
        else        sda_sync <= {sda_sync[0], sda_i};
    end

    // Overflow flag: set by a dropped write, cleared once below full.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cmdq_ovf <= 1'b0;
        else if (cmd_we && cmdq_full)  cmdq_ovf <= 1'b1;
        else if (!cmdq_full)           cmdq_ovf <= 1'b0;
    end

    // Sticky flags: setting events win over the clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxq_ufl <= 1'b0;
            bus_err <= 1'b0;
        end else begin
            if (rxq_re && rxq_empty) rxq_ufl <= 1'b1;
            else if (rxq_re)         rxq_ufl <= 1'b0;
            if (nack_set)            bus_err <= 1'b1;
            else if (rxq_re)         bus_err <= 1'b0;
        end
    end

    assert_ovf_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmdq_full) |=> cmdq_ovf);
    assert_ufl_on_empty_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_re && rxq_empty) |=> rxq_ufl);
    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_re && !rxq_empty && !nack_set) |=> (!rxq_ufl && !bus_err));
    assert_nack_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nack_set |=> bus_err);

endmodule

// File: tb/tb_i2c_cmdq_master.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, with a pulled-up bus and a
// simple slave that drives read data and acknowledge levels.
module tb_i2c_cmdq_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = 8'h00;
    logic       rxq_re = 1'b0;
    logic [7:0] rxq_rdata;
    logic [4:0] div_lo = 5'd0;
    logic [7:0] prescale = 8'd1;
    logic       scl_drive_low, sda_drive_low;
    logic       cmdq_empty, cmdq_ovf, rxq_ufl, rxq_ready, bus_err;

    logic       slv_en = 1'b0;
    logic [7:0] slv_byte = 8'h00;
    int         slv_idx = 0;
    logic       ack_low = 1'b0;
    logic       slv_low;
    wire        scl_line;
    wire        sda_line;

    int      vectors = 0;
    int      misses = 0;
    string   evs = "";
    realtime rise_t [16];
    int      nrise = 0;

    always #2.5 clk = ~clk;

    assign slv_low  = slv_en && (slv_idx < 8) && !slv_byte[3'(7 - slv_idx)];
    assign scl_line = ~scl_drive_low;
    assign sda_line = ~(sda_drive_low | slv_low | ack_low);

    i2c_cmdq_master dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .rxq_re(rxq_re), .rxq_rdata(rxq_rdata), .div_lo(div_lo), .prescale(prescale),
        .sda_i(sda_line), .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .cmdq_empty(cmdq_empty), .cmdq_ovf(cmdq_ovf), .rxq_ufl(rxq_ufl),
        .rxq_ready(rxq_ready), .bus_err(bus_err)
    );

    // Bus monitor: data bits at SCL rise, start and stop on SDA edges while SCL high.
    always @(posedge scl_line) begin
        if (sda_line) evs = {evs, "1"};
        else          evs = {evs, "0"};
        if (nrise < 16) rise_t[nrise] = $realtime;
        nrise++;
    end
    always @(negedge sda_line) if (scl_line) evs = {evs, "S"};
    always @(posedge sda_line) if (scl_line) evs = {evs, "P"};
    always @(negedge scl_line) if (slv_en) slv_idx++;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chks(input string tag, input string act, input string exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual \"%s\" expected \"%s\"", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = b;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic rd_pop();
        @(negedge clk); rxq_re = 1'b1;
        @(negedge clk); rxq_re = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_log(input string tag, input int n);
        int k = 0;
        while (evs.len() < n && k < 20000) begin
            @(negedge clk);
            k++;
        end
        if (evs.len() < n) begin
            vectors++;
            misses++;
            $display("FAIL %s: actual %0d bus events expected %0d", tag, evs.len(), n);
        end
        idle(160);
    endtask

    task automatic t_reset();
        chk("R1 scl idle", int'(scl_line), 1);
        chk("R1 sda idle", int'(sda_line), 1);
        chk("R1 cmdq_empty", int'(cmdq_empty), 1);
        chk("R1 flags", int'({cmdq_ovf, rxq_ufl, rxq_ready, bus_err}), 0);
    endtask

    task automatic t_start_stop();
        evs = "";
        send(8'h15);
        wait_log("R2 start", 2);
        chks("R2 start", evs, "1S");
        send(8'h16);
        wait_log("R2 stop", 4);
        chks("R2 stop", evs, "1S0P");
        chk("R2 parked idle", int'({scl_line, sda_line}), 3);
    endtask

    task automatic t_bits();
        evs = "";
        send(8'h15); send(8'h10); send(8'h11); send(8'h11); send(8'h10);
        wait_log("R3 bits", 6);
        chks("R3 bits", evs, "1S0110");
        chk("R12 drained", int'(cmdq_empty), 1);
    endtask

    task automatic t_txbyte();
        evs = "";
        send(8'h12);
        idle(40);
        chk("R12 empty while awaiting payload", int'(cmdq_empty), 1);
        send(8'h13);
        wait_log("R4 payload 0x13", 8);
        idle(600);
        chks("R4 payload 0x13", evs, "00010011");
        chk("R4 no receive", int'(rxq_ready), 0);
        evs = "";
        send(8'h12); send(8'hA6);
        wait_log("R4 payload 0xA6", 8);
        chks("R4 payload 0xA6", evs, "10100110");
    endtask

    task automatic rx_byte(input logic [7:0] v);
        slv_byte = v; slv_idx = 0; slv_en = 1'b1;
        send(8'h13);
        wait_log("R5 receive", evs.len() + 8);
        slv_en = 1'b0;
    endtask

    task automatic t_rx();
        evs = "";
        rx_byte(8'hA5);
        chks("R5 receive bits", evs, "10100101");
        chk("R5 ready", int'(rxq_ready), 1);
        chk("R5 data", int'(rxq_rdata), 8'hA5);
        rx_byte(8'h3C);
        chk("R5 head kept", int'(rxq_rdata), 8'hA5);
        rd_pop();
        chk("R5 second byte", int'(rxq_rdata), 8'h3C);
        rd_pop();
        chk("R5 drained", int'(rxq_ready), 0);
        evs = "";
        send(8'h11);
        wait_log("R3 nack bit", 1);
        chks("R3 nack bit", evs, "1");
    endtask

    task automatic t_ack();
        evs = "";
        ack_low = 1'b1;
        send(8'h14);
        wait_log("R6 ack", 1);
        ack_low = 1'b0;
        chks("R6 ack level", evs, "0");
        chk("R6 ack keeps bus_err", int'(bus_err), 0);
        send(8'h14);
        wait_log("R6 nack", 2);
        chks("R6 nack level", evs, "01");
        chk("R6 nack sets bus_err", int'(bus_err), 1);
    endtask

    task automatic t_clear();
        rd_pop();
        chk("R9 read clears bus_err", int'(bus_err), 0);
        chk("R8 empty read sets ufl", int'(rxq_ufl), 1);
        rd_pop();
        chk("R9 set wins on repeat", int'(rxq_ufl), 1);
        evs = "";
        rx_byte(8'h5A);
        chk("R5 data 0x5A", int'(rxq_rdata), 8'h5A);
        rd_pop();
        chk("R9 read clears ufl", int'(rxq_ufl), 0);
    endtask

    task automatic t_ovf();
        evs = "";
        send(8'h15);
        for (int i = 0; i < 4; i++) send(8'h10);
        chk("R7 no early ovf", int'(cmdq_ovf), 0);
        send(8'h11);
        chk("R7 drop sets ovf", int'(cmdq_ovf), 1);
        wait_log("R7 drain", 6);
        chk("R7 ovf clears", int'(cmdq_ovf), 0);
        idle(600);
        chks("R7 dropped bit absent", evs, "1S0000");
    endtask

    task automatic t_null();
        evs = "";
        send(8'h00); send(8'h3F); send(8'h17);
        idle(400);
        chks("R10 no activity", evs, "");
        chk("R10 scl parked low", int'(scl_line), 0);
        chk("R10 consumed", int'(cmdq_empty), 1);
    endtask

    task automatic t_timing(input logic [7:0] pre, input logic [4:0] lo, input int exp_ns);
        prescale = pre; div_lo = lo;
        idle(10);
        evs = ""; nrise = 0;
        send(8'h12); send(8'hFF);
        wait_log("R11 timing", 8);
        chk("R11 rise spacing ns", int'($rtoi(rise_t[2] - rise_t[1] + 0.5)), exp_ns);
        chk("R11 rise spacing later", int'($rtoi(rise_t[6] - rise_t[5] + 0.5)), exp_ns);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        idle(6);
        rst_n = 1'b1;
        idle(4);
        evs = ""; nrise = 0;
        t_reset();
        t_start_stop();
        t_bits();
        t_txbyte();
        t_rx();
        t_ack();
        t_clear();
        t_ovf();
        t_null();
        t_timing(8'd0, 5'd0, 495);
        t_timing(8'd2, 5'd3, 1020);
        evs = "";
        send(8'h10);
        send(8'h16);
        wait_log("R2 final stop", 3);
        chks("R2 final stop", evs, "00P");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule